// File: doc/BRIEF.md
# Free-Running Converter Strobe Controller

This block runs an external 8-bit parallel-output analog-to-digital converter that is wired for continuous conversion. The converter's chip select is grounded and its write and read strobes are joined into one active-low line, so each pulse on that line does two jobs. It reads out the finished result and it starts the next conversion. Because the converter needs one start pulse before its first real conversion, the controller issues that pulse on its own after reset. It then waits idle.

When logic inside the chip raises a request, the controller first waits for the conversion to settle. It watches the converter's active-low interrupt, brought in through a two-flop synchronizer. A falling edge on that interrupt restarts the settling count, so the strobe never comes too soon after it. If no interrupt edge arrives, the strobe still follows once the count runs out. The controller then holds the shared strobe low for a fixed time, capturing the data bus while the strobe is low. On release it presents the byte with a one-cycle valid pulse. One shared counter times every wait. Its limit is the parameter WAIT_CYCLES, which defaults to 8 and must be at least 8.

Top module: `adcStrobeCtrl`

## Requirements
- R1: While rst is high at a clock edge, the following cycle shows strobeN high, busy high, dataValid low and dataOut equal to 0.
- R2: After rst falls, strobeN goes low from the first clock edge and stays low for exactly WAIT_CYCLES+2 cycles. One further cycle follows with strobeN high and busy still high, and then busy falls. dataValid stays low throughout this startup pulse.
- R3: When idle (busy low) with req low, the block stays idle with strobeN high. A req high sampled while idle makes busy high in the next cycle, with strobeN still high.
- R4: intN is active low. When no falling edge of intN is seen, strobeN goes low WAIT_CYCLES+1 cycles after busy rises. If intN is driven low on cycle m of the settling wait (1 ≤ m ≤ WAIT_CYCLES-1), the strobe instead falls WAIT_CYCLES+4 cycles after that edge. The strobe never falls fewer than WAIT_CYCLES+3 cycles after an intN falling edge.
- R5: Each accepted request produces exactly one read strobe, low for exactly WAIT_CYCLES+2 cycles.
- R6: dataValid is high for exactly one cycle, the first cycle in which strobeN is high again after a read strobe. In that cycle dataOut equals the dataIn value present in the last strobe-low cycle.
- R7: dataOut holds its value while the strobe is high, and changes on dataIn outside a read strobe have no effect on it.
- R8: busy is high in every state except idle. A req raised while busy is ignored, so no second strobe follows and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Conversion request, sampled only while idle |
| intN | input | 1 | Converter interrupt, active low, asynchronous |
| dataIn | input | 8 | Converter parallel data bus |
| strobeN | output | 1 | Shared active-low write/read strobe |
| dataOut | output | 8 | Last captured conversion result |
| dataValid | output | 1 | One-cycle pulse when dataOut is new |
| busy | output | 1 | High whenever the controller is not idle |

## Verification
The interrupt-gap property assumes that intN falls only while the block is idle or settling. This matches the converter, which signals once per conversion and clears when strobed. The bench therefore lowers intN only on chosen cycles of the settling wait and raises it again as soon as the strobe is seen low. The bench changes dataIn only at the falling clock edge. It holds the wanted byte for the whole strobe-low window and drives its complement elsewhere, so any capture outside that window shows up at dataOut.

// File: rtl/adcStrobePkg.sv
package adcStrobePkg;

  typedef enum logic [3:0] {
    ST_RESET,
    ST_INIT_ON,
    ST_INIT_HOLD,
    ST_INIT_OFF,
    ST_IDLE,
    ST_CONV,
    ST_RD_ON,
    ST_RD_HOLD,
    ST_RD_OFF
  } stateT;

  typedef struct packed {
    logic cntClr;
    logic capture;
    logic strobeOn;
    logic validPulse;
    logic busy;
  } ctrlT;

endpackage

// File: rtl/adcStrobeFsm.sv
module adcStrobeFsm
  import adcStrobePkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic intFall,
  input  logic cntDone,
  output ctrlT ctrl
);

  stateT state;
  stateT nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_RESET;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_RESET:     nextState = ST_INIT_ON;
      ST_INIT_ON:   nextState = ST_INIT_HOLD;
      ST_INIT_HOLD: if (cntDone) nextState = ST_INIT_OFF;
      ST_INIT_OFF:  nextState = ST_IDLE;
      ST_IDLE:      if (req) nextState = ST_CONV;
      // an interrupt edge restarts the settling count instead of leaving
      ST_CONV:      if (cntDone && !intFall) nextState = ST_RD_ON;
      ST_RD_ON:     nextState = ST_RD_HOLD;
      ST_RD_HOLD:   if (cntDone) nextState = ST_RD_OFF;
      ST_RD_OFF:    nextState = ST_IDLE;
      default:      nextState = ST_RESET;
    endcase
  end

  always_comb begin
    ctrl.cntClr     = (nextState != state) || (state == ST_CONV && intFall);
    ctrl.strobeOn   = (state == ST_INIT_ON) || (state == ST_INIT_HOLD) ||
                      (state == ST_RD_ON)   || (state == ST_RD_HOLD);
    ctrl.capture    = (state == ST_RD_ON) || (state == ST_RD_HOLD);
    ctrl.validPulse = (state == ST_RD_OFF);
    ctrl.busy       = (state != ST_IDLE);
  end

endmodule

// File: rtl/adcStrobeDatapath.sv
module adcStrobeDatapath
  import adcStrobePkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int WAIT_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlT              ctrl,
  input  logic              intN,
  input  logic [DATA_W-1:0] dataIn,
  output logic              intFall,
  output logic              cntDone,
  output logic              strobeN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid,
  output logic              busy
);

  localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(WAIT_CYCLES);

  // synchronizer stages plus one history flop for edge detection
  logic [SYNC_STAGES:0] intPipe;
  logic [CNT_W-1:0]     waitCnt;

  always_ff @(posedge clk) begin
    if (rst) intPipe <= '1;
    else     intPipe <= {intPipe[SYNC_STAGES-1:0], intN};
  end

  assign intFall = intPipe[SYNC_STAGES] & ~intPipe[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst || ctrl.cntClr) waitCnt <= '0;
    else if (!cntDone)      waitCnt <= waitCnt + 1'b1;
  end

  assign cntDone = (waitCnt >= CNT_LIMIT);

  always_ff @(posedge clk) begin
    if (rst)               dataOut <= '0;
    else if (ctrl.capture) dataOut <= dataIn;
  end

  assign strobeN   = ~ctrl.strobeOn;
  assign dataValid = ctrl.validPulse;
  assign busy      = ctrl.busy;

endmodule

// File: rtl/adcStrobeCtrl.sv
module adcStrobeCtrl
  import adcStrobePkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int WAIT_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              intN,
  input  logic [DATA_W-1:0] dataIn,
  output logic              strobeN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid,
  output logic              busy
);

  ctrlT ctrl;
  logic intFall;
  logic cntDone;

  adcStrobeFsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .intFall (intFall),
    .cntDone (cntDone),
    .ctrl    (ctrl)
  );

  adcStrobeDatapath #(
    .DATA_W      (DATA_W),
    .WAIT_CYCLES (WAIT_CYCLES),
    .SYNC_STAGES (2)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .intN      (intN),
    .dataIn    (dataIn),
    .intFall   (intFall),
    .cntDone   (cntDone),
    .strobeN   (strobeN),
    .dataOut   (dataOut),
    .dataValid (dataValid),
    .busy      (busy)
  );

endmodule

// File: rtl/adcStrobeChecker.sv
module adcStrobeChecker #(
  parameter int DATA_W      = 8,
  parameter int WAIT_CYCLES = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              intN,
  input logic              strobeN,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataValid,
  input logic              busy
);

  localparam logic [15:0] GAP_MAX = 16'hFFFF;

  logic        strobePrev;
  logic        intPrev;
  logic [15:0] lowRun;
  logic [15:0] sinceInt;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobePrev <= 1'b1;
      intPrev    <= 1'b1;
      lowRun     <= '0;
      sinceInt   <= GAP_MAX;
    end else begin
      strobePrev <= strobeN;
      intPrev    <= intN;
      lowRun     <= strobeN ? 16'd0 : lowRun + 16'd1;
      if (intPrev && !intN)      sinceInt <= '0;
      else if (sinceInt != GAP_MAX) sinceInt <= sinceInt + 16'd1;
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (busy && strobeN && !dataValid && dataOut == '0));

  p_req_start_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && req) |=> (busy && strobeN));

  p_int_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (!strobeN && strobePrev) |-> (sinceInt >= 16'(WAIT_CYCLES + 3)));

  p_strobe_width_r5: assert property (@(posedge clk) disable iff (rst)
    (strobeN && !strobePrev) |-> (lowRun == 16'(WAIT_CYCLES + 2)));

  p_valid_single_r6: assert property (@(posedge clk) disable iff (rst)
    dataValid |=> !dataValid);

  p_valid_on_release_r6: assert property (@(posedge clk) disable iff (rst)
    dataValid |-> (strobeN && !strobePrev));

  p_data_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(dataOut));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (strobeN && !dataValid));

endmodule

bind adcStrobeCtrl adcStrobeChecker #(
  .DATA_W      (DATA_W),
  .WAIT_CYCLES (WAIT_CYCLES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req       (req),
  .intN      (intN),
  .strobeN   (strobeN),
  .dataOut   (dataOut),
  .dataValid (dataValid),
  .busy      (busy)
);

// File: tb/adcStrobeCtrl_test.sv
`timescale 1ns/1ps
module adcStrobeCtrl_test;

  localparam int W  = 8;
  localparam int DW = 8;

  // each entry: {data byte, interrupt cycle in settling wait (0 = none)}
  localparam logic [15:0] VEC [6] = '{
    {8'h00, 8'd0}, {8'hFF, 8'd1}, {8'hA5, 8'd3},
    {8'h5A, 8'd7}, {8'h01, 8'd0}, {8'h80, 8'd5}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic          intN = 1'b1;
  logic [DW-1:0] dataIn = '0;
  logic          strobeN;
  logic [DW-1:0] dataOut;
  logic          dataValid;
  logic          busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  adcStrobeCtrl #(.DATA_W(DW), .WAIT_CYCLES(W)) uut (
    .clk(clk), .rst(rst), .req(req), .intN(intN), .dataIn(dataIn),
    .strobeN(strobeN), .dataOut(dataOut), .dataValid(dataValid), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called right after rst falls at a negedge
  task automatic startupCheck();
    int lowCnt = 0;
    bit validSeen = 1'b0;
    @(negedge clk);
    chk(strobeN == 1'b0, "R2 strobe low on first cycle", strobeN, 0);
    while (!strobeN && lowCnt < 200) begin
      lowCnt++;
      if (dataValid) validSeen = 1'b1;
      @(negedge clk);
    end
    chk(lowCnt == W + 2, "R2 startup pulse width", lowCnt, W + 2);
    chk(busy == 1'b1, "R2 busy during release", busy, 1);
    chk(!validSeen && !dataValid, "R2 no valid in startup", validSeen, 0);
    @(negedge clk);
    chk(busy == 1'b0, "R2 idle after startup", busy, 0);
  endtask

  // called at a negedge while idle
  task automatic doRead(input logic [DW-1:0] data, input int m, input bit extraReq);
    int idx = 0;
    int lowCnt = 1;
    int expIdx = (m == 0) ? W + 2 : m + W + 4;
    req = 1'b1;
    dataIn = ~data;
    while (idx < 200) begin
      @(negedge clk);
      idx++;
      if (idx == 1) req = 1'b0;
      if (m != 0 && idx == m) intN = 1'b0;
      if (extraReq && idx == 3) req = 1'b1;
      if (extraReq && idx == 4) req = 1'b0;
      if (!strobeN) break;
    end
    chk(idx == expIdx, "R4 strobe delay after request", idx, expIdx);
    intN = 1'b1;
    dataIn = data;
    while (lowCnt < 200) begin
      @(negedge clk);
      if (strobeN) break;
      lowCnt++;
    end
    chk(lowCnt == W + 2, "R5 read strobe width", lowCnt, W + 2);
    chk(dataValid == 1'b1, "R6 valid on release", dataValid, 1);
    chk(dataOut == data, "R6 captured data", dataOut, data);
    dataIn = ~data;
    @(negedge clk);
    chk(dataValid == 1'b0, "R6 valid single cycle", dataValid, 0);
    chk(busy == 1'b0, "R8 idle after read", busy, 0);
    chk(dataOut == data, "R7 data held after bus change", dataOut, data);
    if (extraReq) begin
      int extra = 0;
      repeat (20) begin
        @(negedge clk);
        if (!strobeN || busy) extra++;
      end
      chk(extra == 0, "R8 request while busy ignored", extra, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(strobeN == 1'b1, "R1 strobe idle in reset", strobeN, 1);
    chk(busy == 1'b1, "R1 busy in reset", busy, 1);
    chk(dataValid == 1'b0, "R1 no valid in reset", dataValid, 0);
    chk(dataOut == '0, "R1 data cleared", dataOut, 0);
    rst = 1'b0;
    startupCheck();

    begin
      int bad = 0;
      repeat (10) begin
        @(negedge clk);
        if (busy || !strobeN) bad++;
      end
      chk(bad == 0, "R3 stays idle without request", bad, 0);
    end

    for (int i = 0; i < 6; i++) begin
      doRead(VEC[i][15:8], int'(VEC[i][7:0]), 1'b0);
    end

    doRead(8'h3C, 0, 1'b1);

    // reset in the middle of a read strobe
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    begin
      int guard = 0;
      while (strobeN && guard < 200) begin
        @(negedge clk);
        guard++;
      end
    end
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(strobeN == 1'b1, "R1 strobe released by reset", strobeN, 1);
    chk(busy == 1'b1, "R1 busy after mid reset", busy, 1);
    chk(dataValid == 1'b0, "R1 no valid after mid reset", dataValid, 0);
    chk(dataOut == '0, "R1 data cleared by mid reset", dataOut, 0);
    rst = 1'b0;
    startupCheck();
    doRead(8'hC3, 2, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule